// File: doc/BRIEF.md
# Nibble-Split Packet Receiver

This block takes a stream of already deserialised transfer bytes, each with the extra ninth bit that the serial receiver delivers. It rebuilds fixed 11-byte packets from them. A transfer byte of 0xFE is a start code that puts every listening node back to the beginning of a packet. Each transfer byte after the start code carries one nibble in its low four bits, and two transfer bytes form one packet byte. The packet holds a destination address, a source address, eight payload bytes and an 8-bit CRC.

The CRC is accumulated one byte at a time through a 256-entry lookup table while the bytes arrive. The last byte therefore needs only a single compare. When the CRC matches, the block pulses a packet-seen flag. When the low five bits of the destination also equal the node's own ID, it copies the source and the payload into an output bank that is separate from the working buffer, and it pulses a strobe. An idle timer restarts reception when the line stays quiet for too long.

Top module: `nibble_pkt_rx`

## Requirements
- R1: `in_ready` is low during reset and high from the first clock edge after reset. The block never applies back-pressure. A beat is taken on every cycle in which `in_valid` and `in_ready` are both high.
- R2: A beat with `in_flag`=1 and `in_data`=0xFE clears the nibble phase, the byte position and the CRC accumulator. It stores nothing.
- R3: Each other flagged beat supplies a nibble in `in_data[3:0]`, and bits 7:4 are ignored. The first nibble of a pair is the high half of the rebuilt byte and the second nibble is the low half.
- R4: Rebuilt byte positions are: 0 = destination, 1 = source, 2..9 = payload, 10 = CRC. A complete packet is one start code plus 22 nibble beats. On acceptance, `out_src` takes the byte at position 1 and `out_data[8k+7:8k]` takes the byte at position 2+k.
- R5: The CRC starts at 0x00. Bytes 0..9 update it as table[crc XOR byte], where table[v] is v shifted MSB-first through eight steps of polynomial 0x07, with no reflection and no final XOR. A byte at position 10 that differs from the CRC gives no `pkt_seen`, no `new_packet` and no change to the outputs.
- R6: A beat with `in_flag`=0 is treated as corrupt and has no effect on the packet, even when its value is 0xFE.
- R7: When the CRC matches, `pkt_seen` pulses for one cycle. The packet is accepted only if `dest[4:0]` equals `node_id`. Otherwise the outputs do not change and `new_packet` stays low.
- R8: `out_src` and `out_data` change only on an accepted packet. When they change, `new_packet` is high for exactly one cycle, and that cycle follows the edge that took the beat carrying the CRC's low nibble.
- R9: A byte completed after the CRC position resets the receive state to position 0 without storing the byte. The 22 nibbles that follow are then decoded as a new packet.
- R10: After `TIMEOUT_CYCLES` cycles with no flagged beat, the receive state returns to position 0 with phase and CRC cleared. Corrupt beats do not restart the timer.
- R11: After reset, `out_data` and `out_src` are zero and `pkt_seen` and `new_packet` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 5 | Address of this node |
| in_valid | input | 1 | Transfer byte valid |
| in_ready | output | 1 | Always ready after reset |
| in_data | input | 8 | Transfer byte |
| in_flag | input | 1 | Ninth bit; 0 marks the byte as corrupt |
| pkt_seen | output | 1 | One-cycle pulse: CRC matched (any destination) |
| new_packet | output | 1 | One-cycle pulse: outputs updated for this node |
| out_src | output | 8 | Source byte of the last accepted packet |
| out_data | output | 64 | Payload of the last accepted packet, byte k in bits 8k+7:8k |

## Verification
Every result of a packet is due one clock edge after the beat that carries the CRC's low nibble. On that edge `pkt_seen`, `new_packet` and the output bank all change together. The bench drives each beat on a falling edge and reads the outputs on the falling edge right after the last beat, which is exactly that cycle. It then checks the following falling edge to confirm the strobe has fallen. Timeout tests leave a gap a few cycles longer than `TIMEOUT_CYCLES`, and a matching short gap serves as a control in which the state must survive.

// File: rtl/nrx_pkg.sv
package nrx_pkg;
  localparam int BYTE_W     = 8;
  localparam int NIB_W      = 4;
  localparam int ADDR_W     = 5;
  localparam int PKT_LEN    = 11;
  localparam int CRC_POS    = PKT_LEN - 1;
  localparam int DATA_BASE  = 2;
  localparam int DATA_N     = CRC_POS - DATA_BASE;
  localparam int IDX_W      = $clog2(PKT_LEN + 1);
  localparam int TAB_N      = 1 << BYTE_W;
  localparam logic [BYTE_W-1:0] START_CODE = 8'hFE;
  localparam logic [BYTE_W-1:0] CRC_POLY   = 8'h07;

  function automatic logic [BYTE_W-1:0] crc_entry(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] c;
    c = v;
    for (int i = 0; i < BYTE_W; i++)
      c = c[BYTE_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/nrx_crc_rom.sv
module nrx_crc_rom
  import nrx_pkg::*;
(
  input  logic [BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0] value
);
  logic [BYTE_W-1:0] tab [TAB_N];

  for (genvar g = 0; g < TAB_N; g++) begin : g_entry
    assign tab[g] = crc_entry(BYTE_W'(g));
  end

  assign value = tab[addr];
endmodule

// File: rtl/nrx_idle_timer.sv
module nrx_idle_timer #(
  parameter int TIMEOUT_CYCLES = 93750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (kick)         cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expire = !kick && (cnt == LIMIT - 1'b1);

  a_r10_single_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/nrx_frame.sv
module nrx_frame
  import nrx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat,
  input  logic                     flag,
  input  logic [BYTE_W-1:0]        din,
  input  logic [ADDR_W-1:0]        node_id,
  input  logic                     expire,
  output logic                     ev_seen,
  output logic                     ev_commit,
  output logic [BYTE_W-1:0]        src_byte,
  output logic [DATA_N*BYTE_W-1:0] payload
);
  logic              phase;
  logic [NIB_W-1:0]  hi_nib;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] crc, crc_next, rebuilt;
  logic [BYTE_W-1:0] work [CRC_POS];
  logic              good, is_start, byte_done, at_crc;

  assign good      = beat && flag;
  assign is_start  = (din == START_CODE);
  assign byte_done = good && !is_start && phase;
  assign rebuilt   = {hi_nib, din[NIB_W-1:0]};
  assign at_crc    = (idx == IDX_W'(CRC_POS));
  assign ev_seen   = byte_done && at_crc && (rebuilt == crc);
  assign ev_commit = ev_seen && (work[0][ADDR_W-1:0] == node_id);

  nrx_crc_rom u_rom (.addr(crc ^ rebuilt), .value(crc_next));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      hi_nib <= '0;
      idx    <= '0;
      crc    <= '0;
      for (int i = 0; i < CRC_POS; i++) work[i] <= '0;
    end else if (expire || (good && is_start)) begin
      phase <= 1'b0;
      idx   <= '0;
      crc   <= '0;
    end else if (good) begin
      if (!phase) begin
        hi_nib <= din[NIB_W-1:0];
        phase  <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (idx < IDX_W'(CRC_POS)) begin
          work[idx] <= rebuilt;
          crc       <= crc_next;
          idx       <= idx + 1'b1;
        end else if (at_crc) begin
          idx <= IDX_W'(CRC_POS + 1);
        end else begin
          idx <= '0;
          crc <= '0;
        end
      end
    end
  end

  assign src_byte = work[1];
  for (genvar k = 0; k < DATA_N; k++) begin : g_pay
    assign payload[k*BYTE_W +: BYTE_W] = work[DATA_BASE + k];
  end

  a_r6_corrupt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !flag && !expire) |=> ($stable(idx) && $stable(phase) && $stable(crc)));
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && flag && din == START_CODE) |=> (idx == '0 && !phase && crc == '0));
  a_r9_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(CRC_POS + 1));
  a_r10_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (idx == '0 && !phase));
endmodule

// File: rtl/nrx_out_bank.sv
module nrx_out_bank
  import nrx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_seen,
  input  logic                     ev_commit,
  input  logic [BYTE_W-1:0]        src_in,
  input  logic [DATA_N*BYTE_W-1:0] data_in,
  output logic                     pkt_seen,
  output logic                     new_packet,
  output logic [BYTE_W-1:0]        out_src,
  output logic [DATA_N*BYTE_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_seen   <= 1'b0;
      new_packet <= 1'b0;
      out_src    <= '0;
      out_data   <= '0;
    end else begin
      pkt_seen   <= ev_seen;
      new_packet <= ev_commit;
      if (ev_commit) begin
        out_src  <= src_in;
        out_data <= data_in;
      end
    end
  end

  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !new_packet |-> ($stable(out_data) && $stable(out_src)));
  a_r7_commit_needs_crc: assert property (@(posedge clk) disable iff (!rst_n)
    new_packet |-> pkt_seen);
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    new_packet |=> !new_packet);
endmodule

// File: rtl/nibble_pkt_rx.sv
module nibble_pkt_rx #(
  parameter int TIMEOUT_CYCLES = 93750
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  node_id,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_flag,
  output logic        pkt_seen,
  output logic        new_packet,
  output logic [7:0]  out_src,
  output logic [63:0] out_data
);
  import nrx_pkg::*;

  logic                     rdy_q, beat, expire, ev_seen, ev_commit;
  logic [BYTE_W-1:0]        src_byte;
  logic [DATA_N*BYTE_W-1:0] payload;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q;
  assign beat     = in_valid && rdy_q;

  nrx_idle_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(beat && in_flag), .expire(expire));

  nrx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .beat(beat), .flag(in_flag), .din(in_data),
    .node_id(node_id), .expire(expire), .ev_seen(ev_seen),
    .ev_commit(ev_commit), .src_byte(src_byte), .payload(payload));

  nrx_out_bank u_bank (
    .clk(clk), .rst_n(rst_n), .ev_seen(ev_seen), .ev_commit(ev_commit),
    .src_in(src_byte), .data_in(payload), .pkt_seen(pkt_seen),
    .new_packet(new_packet), .out_src(out_src), .out_data(out_data));

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

// File: tb/tb_nibble_pkt_rx.sv
module tb_nibble_pkt_rx;
  localparam int TMO = 40;
  localparam logic [4:0] NODE = 5'h0A;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_flag = 0;
  logic [7:0] in_data = 0;
  logic in_ready, pkt_seen, new_packet;
  logic [7:0] out_src;
  logic [63:0] out_data;
  logic [4:0] node_id = NODE;

  always #4 clk = ~clk;

  nibble_pkt_rx #(.TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_flag(in_flag),
    .pkt_seen(pkt_seen), .new_packet(new_packet), .out_src(out_src),
    .out_data(out_data));

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0]  pk [11];
  logic [63:0] exp_data = '0, cand_data;
  logic [7:0]  exp_src = '0, cand_src;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      c ^= pk[i];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic build(input logic [7:0] dest, input logic [7:0] src,
                       input logic [7:0] base, input bit bad);
    pk[0] = dest; pk[1] = src;
    for (int k = 0; k < 8; k++) begin
      pk[2+k] = base + 8'(k * 37);
      cand_data[k*8 +: 8] = pk[2+k];
    end
    pk[10] = crc8(10) ^ (bad ? 8'h01 : 8'h00);
    cand_src = src;
  endtask

  task automatic beat(input logic [7:0] d, input logic f);
    in_valid = 1; in_data = d; in_flag = f;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_nibs(input int from, input int cnt, input logic [3:0] junk,
                           input int bad_at, input logic [7:0] bad_val);
    for (int i = from; i < from + cnt; i++) begin
      logic [3:0] nib;
      if (i == bad_at) beat(bad_val, 1'b0);
      nib = (i % 2 == 0) ? pk[i/2][7:4] : pk[i/2][3:0];
      beat({junk, nib}, 1'b1);
    end
  endtask

  task automatic expect_result(input string tag, input bit seen, input bit acc);
    chk({tag, " pkt_seen"}, 64'(pkt_seen), 64'(seen));
    chk({tag, " new_packet"}, 64'(new_packet), 64'(acc));
    if (acc) begin exp_data = cand_data; exp_src = cand_src; end
    chk({tag, " out_data"}, out_data, exp_data);
    chk({tag, " out_src"}, 64'(out_src), 64'(exp_src));
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", 64'(in_ready), 64'd1);
    chk("R11 out_data reset", out_data, 64'd0);
    chk("R11 out_src reset", 64'(out_src), 64'd0);
    chk("R11 strobes reset", 64'({pkt_seen, new_packet}), 64'd0);
  endtask

  task automatic t_basic;
    build(8'h0A, 8'h13, 8'h21, 0);
    beat(8'hFE, 1);
    send_nibs(0, 11, 4'h0, -1, 8'h00);
    chk("R1 ready mid-stream", 64'(in_ready), 64'd1);
    send_nibs(11, 11, 4'h0, -1, 8'h00);
    expect_result("R4 R5 R8 basic", 1, 1);
    @(negedge clk);
    chk("R8 strobe one cycle", 64'(new_packet), 64'd0);
  endtask

  task automatic t_junk_upper;
    build(8'hEA, 8'h44, 8'h5C, 0);
    beat(8'hFE, 1);
    send_nibs(0, 22, 4'h5, -1, 8'h00);
    expect_result("R3 R7 upper bits ignored", 1, 1);
  endtask

  task automatic t_bad_crc;
    build(8'h0A, 8'h77, 8'h90, 1);
    beat(8'hFE, 1);
    send_nibs(0, 22, 4'h0, -1, 8'h00);
    expect_result("R5 bad crc", 0, 0);
  endtask

  task automatic t_other_addr;
    build(8'h0B, 8'h66, 8'h31, 0);
    beat(8'hFE, 1);
    send_nibs(0, 22, 4'h0, -1, 8'h00);
    expect_result("R7 other address", 1, 0);
  endtask

  task automatic t_resync;
    build(8'h03, 8'h11, 8'h07, 0);
    beat(8'hFE, 1);
    send_nibs(0, 9, 4'h0, -1, 8'h00);
    build(8'h0A, 8'h52, 8'hA3, 0);
    beat(8'hFE, 1);
    send_nibs(0, 22, 4'h0, -1, 8'h00);
    expect_result("R2 start code resync", 1, 1);
  endtask

  task automatic t_corrupt;
    build(8'h0A, 8'h29, 8'h4E, 0);
    beat(8'hFE, 1);
    send_nibs(0, 9, 4'h0, 5, 8'hFE);
    send_nibs(9, 13, 4'h0, 14, 8'h05);
    expect_result("R6 corrupt beats ignored", 1, 1);
  endtask

  task automatic t_overflow;
    build(8'h0A, 8'h3D, 8'h12, 0);
    beat(8'hFE, 1);
    send_nibs(0, 22, 4'h0, -1, 8'h00);
    expect_result("R9 first packet", 1, 1);
    beat(8'h00, 1); beat(8'h00, 1);
    build(8'h0A, 8'hC4, 8'h6B, 0);
    send_nibs(0, 22, 4'h0, -1, 8'h00);
    expect_result("R9 overflow resets to position 0", 1, 1);
    build(8'h0A, 8'h88, 8'hD0, 0);
    send_nibs(0, 22, 4'h0, -1, 8'h00);
    expect_result("R9 control without extra pair", 0, 0);
  endtask

  task automatic t_timeout;
    build(8'h03, 8'h01, 8'h02, 0);
    beat(8'hFE, 1);
    send_nibs(0, 11, 4'h0, -1, 8'h00);
    repeat (TMO + 5) @(negedge clk);
    build(8'h0A, 8'h5A, 8'hE1, 0);
    send_nibs(0, 22, 4'h0, -1, 8'h00);
    expect_result("R10 timeout restarts", 1, 1);
    build(8'h03, 8'h01, 8'h02, 0);
    beat(8'hFE, 1);
    send_nibs(0, 11, 4'h0, -1, 8'h00);
    repeat (3) @(negedge clk);
    build(8'h0A, 8'h6C, 8'h19, 0);
    send_nibs(0, 22, 4'h0, -1, 8'h00);
    expect_result("R10 short gap keeps state", 0, 0);
    build(8'h03, 8'h01, 8'h02, 0);
    beat(8'hFE, 1);
    send_nibs(0, 11, 4'h0, -1, 8'h00);
    for (int i = 0; i < TMO + 5; i++) beat(8'h01, 0);
    build(8'h0A, 8'h6C, 8'h19, 0);
    send_nibs(0, 22, 4'h0, -1, 8'h00);
    expect_result("R10 R6 corrupt beats do not kick timer", 1, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_basic;
    t_junk_upper;
    t_bad_crc;
    t_other_addr;
    t_resync;
    t_corrupt;
    t_overflow;
    t_timeout;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule